// File: doc/BRIEF.md
# Retimer Mode and Output Control

This block is the control plane of a four-input serial video retimer. It takes the input channel choice, the rate-mode choice, an active-low mute, a forced-bypass request, a clock-output enable, the PLL lock indication and the rate class reported by the rate detector. From these it derives a one-hot select for the input multiplexer, the retiming-bypass control, a drive code for each of the two serial outputs, a qualified lock indicator and a registered SD/HD flag.

Every output is registered and follows its inputs after exactly one clock. Mute takes precedence over everything else. Forced bypass comes next. Automatic bypass, driven by lock and rate support, comes last. The second output is either a second data copy or the rate clock. In clock mode it goes silent whenever retiming is bypassed, because a recovered clock has no meaning in that state. The SD/HD flag is captured only when qualified lock is gained, is held for as long as lock stays up, and reads HD (low) whenever lock is down.

Top module: `reclk_ctrl`

## Requirements
- R1: The one-hot multiplexer select `mux_sel_oh` has bit k set, and only bit k, when `in_sel` equals k (00, 01, 10, 11 give bits 0, 1, 2, 3), one clock after `in_sel` is applied.
- R2: While `mute_n` is low, both `out1_drv` and `out2_drv` read 2'b01 (true leg low, complement leg high), whatever the bypass, lock and clock-enable inputs are.
- R3: While `bypass_force` is high, `retime_bypass` is high one clock later.
- R4: While `bypass_force` is low, `retime_bypass` is high exactly when qualified lock is absent. Qualified lock means `pll_lock` is high and the detected rate is supported in the current mode.
- R5: Rate support, with `det_rate` coded 00 none, 01 143 Mbps, 10 270 Mbps, 11 HD, and `rate_mode` coded 00 automatic, 01 fixed 270, 10 fixed HD: automatic mode supports 01, 10 and 11; fixed 270 supports only 10; fixed HD supports only 11; 00 is never supported.
- R6: `rate_mode` 11 is a test mode: `retime_bypass` is high and `lock_ind` is low one clock later.
- R7: With `mute_n` high, `out1_drv` reads 2'b10 (live data). `out2_drv` reads 2'b10 when `clk_out_en` is low, and 2'b11 (live clock) when `clk_out_en` is high and retiming is not bypassed. `out2_is_clk` follows `clk_out_en`.
- R8: With `clk_out_en` high and retiming bypassed, `out2_drv` reads 2'b01 (muted) even while `mute_n` is high.
- R9: In the cycle where qualified lock is gained, the SD/HD flag `sd_flag` captures 1 for a detected rate of 01 or 10 and 0 for 11. It becomes visible together with `lock_ind`.
- R10: `sd_flag` is low whenever `lock_ind` is low.
- R11: While qualified lock stays high, `sd_flag` holds its value even if `det_rate` changes.
- R12: During synchronous reset the outputs read: `mux_sel_oh` 0001, `retime_bypass` 1, both drive codes 2'b01, `out2_is_clk` 0, `lock_ind` 0, `sd_flag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sel | input | 2 | Serial input channel choice |
| rate_mode | input | 2 | Rate mode: automatic, fixed SD, fixed HD, test |
| mute_n | input | 1 | Output mute, active low |
| bypass_force | input | 1 | Forces retiming bypass when high |
| clk_out_en | input | 1 | Second output carries the rate clock when high |
| pll_lock | input | 1 | PLL lock indication |
| det_rate | input | 2 | Detected rate class |
| mux_sel_oh | output | 4 | One-hot input multiplexer select |
| retime_bypass | output | 1 | Data passes through without retiming |
| out1_drv | output | 2 | Drive code of the first serial output |
| out2_drv | output | 2 | Drive code of the second serial output |
| out2_is_clk | output | 1 | Second output is in clock function |
| lock_ind | output | 1 | Qualified lock indicator |
| sd_flag | output | 1 | High for SD rates, low for HD or unlocked |

## Verification
The priority chain is tried with mute, forced bypass and lock toggled in every combination, under both second-output functions. This separates a mute that fails to override bypass from a clock-mode mute that wrongly ignores bypass. Each rate mode is crossed with every detected-rate class, which shows whether the 143 Mbps rate is accepted outside automatic mode and whether code 11 always forces bypass. The SD/HD flag is driven through lock acquisition at SD, 143 Mbps and HD rates, then through a detected-rate change while locked and a drop of lock. This distinguishes a flag that is captured at acquisition from one that tracks the detector continuously.

// File: rtl/rc_pkg.sv
// Package: shared encodings for the retimer control plane.
// Assumes two-bit rate mode and detected-rate codes as stated in the brief.
package rc_pkg;

    // Drive code of a serial output: muted state forces true low, complement high.
    typedef enum logic [1:0] {
        DRV_IDLE  = 2'b00,
        DRV_MUTED = 2'b01,
        DRV_DATA  = 2'b10,
        DRV_CLOCK = 2'b11
    } drv_t;

    // Rate-mode selection.
    typedef enum logic [1:0] {
        RM_AUTO = 2'b00,
        RM_SD   = 2'b01,
        RM_HD   = 2'b10,
        RM_TEST = 2'b11
    } rate_mode_t;

    // Detected rate class from the rate detector.
    typedef enum logic [1:0] {
        DET_NONE = 2'b00,
        DET_LOW  = 2'b01,
        DET_SD   = 2'b10,
        DET_HD   = 2'b11
    } det_rate_t;

    // True when the detected class is allowed in the given mode.
    function automatic logic rate_supported(input rate_mode_t mode, input det_rate_t det);
        logic ok;
        case (mode)
            RM_AUTO: ok = (det != DET_NONE);
            RM_SD:   ok = (det == DET_SD);
            RM_HD:   ok = (det == DET_HD);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // True when the detected class counts as a standard-definition rate.
    function automatic logic rate_is_sd(input det_rate_t det);
        return (det == DET_LOW) || (det == DET_SD);
    endfunction

endpackage

// File: rtl/rc_sel_decode.sv
// Module: registered one-hot decode of the input channel choice.
// Assumes N_IN is a power of two equal to 2**SEL_W.
module rc_sel_decode #(
    parameter int N_IN  = 4,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N_IN-1:0]  oh_o
);

    logic [N_IN-1:0] oh_d;

    // One comparator per channel builds the next one-hot value.
    for (genvar k = 0; k < N_IN; k++) begin : g_cmp
        assign oh_d[k] = (sel_i == SEL_W'(k));
    end

    // Register the select; reset points at channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n) oh_o <= N_IN'(1);
        else        oh_o <= oh_d;
    end

endmodule

// File: rtl/rc_rate_qual.sv
// Module: combinational rate qualification.
// Decides whether the PLL lock is valid for the current mode and detected rate.
// Assumes det_rate is stable while pll_lock is high.
module rc_rate_qual
    import rc_pkg::*;
(
    input  rate_mode_t mode_i,
    input  det_rate_t  det_i,
    input  logic       pll_lock_i,
    output logic       lock_ok_o,
    output logic       test_o,
    output logic       is_sd_o
);

    // Qualify lock with rate support and the test-mode override.
    always_comb begin
        test_o    = (mode_i == RM_TEST);
        lock_ok_o = pll_lock_i && !test_o && rate_supported(mode_i, det_i);
        is_sd_o   = rate_is_sd(det_i);
    end

endmodule

// File: rtl/rc_sd_track.sv
// Module: qualified-lock register and SD/HD flag.
// The flag is captured on a lock-gain event, held while locked, and cleared when unlocked.
// Assumes lock_ok_i is synchronous to clk.
module rc_sd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_ok_i,
    input  logic is_sd_i,
    output logic lock_q,
    output logic sd_q
);

    logic gain;

    // A lock-gain event is qualified lock now with no lock last cycle.
    assign gain = lock_ok_i && !lock_q;

    // Track qualified lock one cycle behind its inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_ok_i;
    end

    // Capture on gain, clear on loss, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          sd_q <= 1'b0;
        else if (!lock_ok_i) sd_q <= 1'b0;
        else if (gain)       sd_q <= is_sd_i;
    end

endmodule

// File: rtl/rc_out_ctrl.sv
// Module: bypass and output drive control.
// Priority: mute, then forced bypass or test mode, then automatic bypass from lock.
// Assumes all inputs are synchronous to clk.
module rc_out_ctrl
    import rc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mute_n_i,
    input  logic force_i,
    input  logic test_i,
    input  logic clk_en_i,
    input  logic lock_ok_i,
    output logic bypass_q,
    output drv_t drv1_q,
    output drv_t drv2_q,
    output logic is_clk_q
);

    logic bypass_d;
    drv_t drv1_d;
    drv_t drv2_d;

    // Resolve bypass and drive codes in priority order.
    always_comb begin
        bypass_d = force_i || test_i || !lock_ok_i;
        if (!mute_n_i) begin
            drv1_d = DRV_MUTED;
            drv2_d = DRV_MUTED;
        end else begin
            drv1_d = DRV_DATA;
            if (!clk_en_i)    drv2_d = DRV_DATA;
            else if (bypass_d) drv2_d = DRV_MUTED;
            else              drv2_d = DRV_CLOCK;
        end
    end

    // Register controls; reset holds outputs muted and bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_q <= 1'b1;
            drv1_q   <= DRV_MUTED;
            drv2_q   <= DRV_MUTED;
            is_clk_q <= 1'b0;
        end else begin
            bypass_q <= bypass_d;
            drv1_q   <= drv1_d;
            drv2_q   <= drv2_d;
            is_clk_q <= clk_en_i;
        end
    end

endmodule

// File: rtl/reclk_ctrl.sv
// Module: top of the retimer control plane.
// Joins select decode, rate qualification, SD/HD tracking and output control.
// All outputs follow their inputs after one clock.
module reclk_ctrl #(
    parameter int N_IN  = 4,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] in_sel,
    input  logic [1:0]       rate_mode,
    input  logic             mute_n,
    input  logic             bypass_force,
    input  logic             clk_out_en,
    input  logic             pll_lock,
    input  logic [1:0]       det_rate,
    output logic [N_IN-1:0]  mux_sel_oh,
    output logic             retime_bypass,
    output logic [1:0]       out1_drv,
    output logic [1:0]       out2_drv,
    output logic             out2_is_clk,
    output logic             lock_ind,
    output logic             sd_flag
);
    import rc_pkg::*;

    logic lock_ok;
    logic test_mode;
    logic is_sd;
    drv_t drv1;
    drv_t drv2;

    rc_sel_decode #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (in_sel),
        .oh_o  (mux_sel_oh)
    );

    rc_rate_qual u_qual (
        .mode_i     (rate_mode_t'(rate_mode)),
        .det_i      (det_rate_t'(det_rate)),
        .pll_lock_i (pll_lock),
        .lock_ok_o  (lock_ok),
        .test_o     (test_mode),
        .is_sd_o    (is_sd)
    );

    rc_sd_track u_sd (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_ok_i (lock_ok),
        .is_sd_i   (is_sd),
        .lock_q    (lock_ind),
        .sd_q      (sd_flag)
    );

    rc_out_ctrl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mute_n_i  (mute_n),
        .force_i   (bypass_force),
        .test_i    (test_mode),
        .clk_en_i  (clk_out_en),
        .lock_ok_i (lock_ok),
        .bypass_q  (retime_bypass),
        .drv1_q    (drv1),
        .drv2_q    (drv2),
        .is_clk_q  (out2_is_clk)
    );

    assign out1_drv = drv1;
    assign out2_drv = drv2;

endmodule

// File: rtl/reclk_ctrl_chk.sv
// Checker: temporal properties of the retimer control plane, bound to the top.
module reclk_ctrl_chk #(
    parameter int N_IN  = 4,
    parameter int SEL_W = $clog2(N_IN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] in_sel,
    input logic [1:0]       rate_mode,
    input logic             mute_n,
    input logic             bypass_force,
    input logic             clk_out_en,
    input logic [N_IN-1:0]  mux_sel_oh,
    input logic             retime_bypass,
    input logic [1:0]       out1_drv,
    input logic [1:0]       out2_drv,
    input logic             lock_ind,
    input logic             sd_flag
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(mux_sel_oh) == 1) && mux_sel_oh[$past(in_sel)]); // R1

    AST_MUTE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |=> (out1_drv == 2'b01) && (out2_drv == 2'b01)); // R2

    AST_FORCE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_force |=> retime_bypass); // R3

    AST_TEST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_mode == 2'b11) |=> retime_bypass && !lock_ind); // R6

    AST_CLK_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n && clk_out_en && bypass_force) |=> (out2_drv == 2'b01)); // R8

    AST_SD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ind |-> !sd_flag); // R10

    AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ind && $past(lock_ind)) |-> $stable(sd_flag)); // R11

endmodule

bind reclk_ctrl reclk_ctrl_chk #(.N_IN(N_IN), .SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_sel        (in_sel),
    .rate_mode     (rate_mode),
    .mute_n        (mute_n),
    .bypass_force  (bypass_force),
    .clk_out_en    (clk_out_en),
    .mux_sel_oh    (mux_sel_oh),
    .retime_bypass (retime_bypass),
    .out1_drv      (out1_drv),
    .out2_drv      (out2_drv),
    .lock_ind      (lock_ind),
    .sd_flag       (sd_flag)
);

// File: tb/sim_reclk_ctrl.sv
// Bench: behavioural reference model compared on every clock.
module sim_reclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] in_sel;
    logic [1:0] rate_mode;
    logic       mute_n;
    logic       bypass_force;
    logic       clk_out_en;
    logic       pll_lock;
    logic [1:0] det_rate;
    logic [3:0] mux_sel_oh;
    logic       retime_bypass;
    logic [1:0] out1_drv;
    logic [1:0] out2_drv;
    logic       out2_is_clk;
    logic       lock_ind;
    logic       sd_flag;

    integer n_checks = 0;
    integer n_fails  = 0;
    integer cycles   = 0;
    integer m_lock   = 0;
    integer m_sd     = 0;

    always #10 clk = ~clk;

    reclk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_sel(in_sel), .rate_mode(rate_mode),
        .mute_n(mute_n), .bypass_force(bypass_force), .clk_out_en(clk_out_en),
        .pll_lock(pll_lock), .det_rate(det_rate), .mux_sel_oh(mux_sel_oh),
        .retime_bypass(retime_bypass), .out1_drv(out1_drv), .out2_drv(out2_drv),
        .out2_is_clk(out2_is_clk), .lock_ind(lock_ind), .sd_flag(sd_flag)
    );

    task automatic check(input string req, input string what, input integer act, input integer exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: predict from current inputs, then compare after the edge.
    task automatic step(input string req);
        integer sup, lk, byp, e1, e2, esel;
        case (rate_mode)
            2'd0: sup = (det_rate != 0);
            2'd1: sup = (det_rate == 2);
            2'd2: sup = (det_rate == 3);
            default: sup = 0;
        endcase
        lk  = (pll_lock && sup) ? 1 : 0;
        byp = (bypass_force || !lk) ? 1 : 0;
        if (!rst_n) begin
            esel = 1; byp = 1; e1 = 1; e2 = 1; lk = 0; m_sd = 0;
        end else begin
            esel = 1 << in_sel;
            if (!mute_n) begin e1 = 1; e2 = 1; end
            else begin
                e1 = 2;
                e2 = !clk_out_en ? 2 : (byp ? 1 : 3);
            end
            if (!lk) m_sd = 0;
            else if (m_lock == 0) m_sd = (det_rate == 1 || det_rate == 2) ? 1 : 0;
        end
        m_lock = lk;
        @(posedge clk);
        #5;
        check(req, "mux_sel_oh", mux_sel_oh, esel);
        check(req, "retime_bypass", retime_bypass, byp);
        check(req, "out1_drv", out1_drv, e1);
        check(req, "out2_drv", out2_drv, e2);
        check(req, "out2_is_clk", out2_is_clk, rst_n ? clk_out_en : 0);
        check(req, "lock_ind", lock_ind, m_lock);
        check(req, "sd_flag", sd_flag, m_sd);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_sel = 2'd2; rate_mode = 2'd0; mute_n = 1'b1;
        bypass_force = 1'b0; clk_out_en = 1'b1; pll_lock = 1'b1; det_rate = 2'd3;
        #5;
        step("R12"); step("R12");
        rst_n = 1'b1;
        pll_lock = 1'b0; clk_out_en = 1'b0;
        for (int s = 0; s < 4; s++) begin in_sel = 2'(s); step("R1"); end
        // Lock gain at HD, then SD class change while held.
        pll_lock = 1'b1; det_rate = 2'd3; step("R9"); step("R9");
        det_rate = 2'd2; step("R11"); step("R11");
        pll_lock = 1'b0; step("R10");
        // 143 Mbps and 270 Mbps acquisition.
        pll_lock = 1'b1; det_rate = 2'd1; step("R9"); step("R9");
        pll_lock = 1'b0; step("R10");
        det_rate = 2'd2; pll_lock = 1'b1; step("R9");
        // Rate mode crossed with every detected class, with and without lock.
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 4; d++) begin
                rate_mode = 2'(m); det_rate = 2'(d);
                pll_lock = 1'b0; step("R4");
                pll_lock = 1'b1; step((m == 3) ? "R6" : "R5"); step("R5");
            end
        end
        rate_mode = 2'd0; det_rate = 2'd2;
        // Priority chain over mute, force, lock and clock enable.
        for (int p = 0; p < 16; p++) begin
            mute_n = p[0]; bypass_force = p[1]; pll_lock = p[2]; clk_out_en = p[3];
            step(!p[0] ? "R2" : (p[3] ? "R8" : "R3"));
        end
        mute_n = 1'b1; bypass_force = 1'b0; pll_lock = 1'b1; clk_out_en = 1'b1;
        step("R7"); step("R7");
        clk_out_en = 1'b0; step("R7");
        // Locked flag survives forced bypass and mute.
        det_rate = 2'd3; pll_lock = 1'b0; step("R10");
        pll_lock = 1'b1; step("R9");
        bypass_force = 1'b1; mute_n = 1'b0; det_rate = 2'd1; step("R11"); step("R11");
        rst_n = 1'b0; step("R12"); step("R12");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule